// File: doc/BRIEF.md
# Half-Cycle Amplitude Limiter

This block sits in a sample stream between a waveform source and a DAC. It changes the two halves of a waveform on their own, which makes asymmetric output from any symmetric source. Each sample is offset-binary, and code 128 is the zero line. The positive half and the negative half each have a limit setting. A limit runs from 0 to 1000 in steps of one tenth of a percent of full scale.

A two-bit mode picks how the limits are applied:
- A hard clamp cuts off anything beyond the limit.
- A per-half scale shrinks each half in proportion to its own limit.
- A whole-wave scale shrinks both halves by one shared factor, so the shape is kept.
- A fourth code passes samples through unchanged.

Results move through a two-stage pipeline, and a valid strobe travels with the data. The source can therefore push one sample per clock. The same rules hold for every waveform shape.

Top module: `halfCycleLimiter`

## Requirements
- R1: A sample accepted with `inValid` high appears on `outSample` with `outValid` high exactly two clock edges later. `outValid` is low during reset and for any cycle whose input two edges earlier was not valid.
- R2: Magnitude is measured from code 128. Codes 128 to 255 are the positive half, with a full-scale magnitude of 127. Codes 0 to 127 are the negative half, with a full-scale magnitude of 128. Every computed magnitude is rounded toward zero, and the result is placed back on the same side of 128.
- R3: With mode 2'b00 (clamp), the threshold is floor(FS*L/1000), where FS is the full-scale magnitude of that half and L is that half's limit. A sample whose magnitude does not exceed the threshold passes unchanged. A larger magnitude is replaced by the threshold.
- R4: With mode 2'b01 (per-half scale), the output magnitude is floor(m*L/1000). Here m is the input magnitude and L is the limit of the sample's own half. The other half's limit has no effect.
- R5: With mode 2'b10 (whole-wave scale), both halves use the smaller of the two limits as the factor: floor(m*min(Lpos,Lneg)/1000).
- R6: A limit of 1000 leaves that half unchanged in modes 2'b00 and 2'b01. In mode 2'b10, limits of 1000 on both halves leave every sample unchanged.
- R7: Mode 2'b11 passes every sample through unchanged, whatever the limits are.
- R8: A limit code above 1000 behaves exactly like 1000.
- R9: The output never crosses the zero line, and its magnitude never exceeds the input magnitude.
- R10: While `outValid` is low after reset, `outSample` keeps its last value. Its reset value is 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample strobe |
| inSample | input | 8 | Offset-binary input sample |
| posLimit | input | 10 | Positive-half limit, 0..1000 in 0.1% steps |
| negLimit | input | 10 | Negative-half limit, 0..1000 in 0.1% steps |
| mode | input | 2 | 00 clamp, 01 per-half scale, 10 whole-wave scale, 11 bypass |
| outValid | output | 1 | Output sample strobe |
| outSample | output | 8 | Processed offset-binary sample |

## Verification
The bound checker watches several properties on every cycle:
- the two-cycle valid latency;
- that an output never changes side of the zero line and never grows in magnitude;
- exact pass-through in bypass mode;
- that a full-scale limit leaves a half untouched.

The exact arithmetic of each mode can only be shown by the bench's scenarios. This covers the clamp threshold, the rounding toward zero, the choice of the smaller limit in whole-wave mode, and the handling of out-of-range limit codes. The bench scenarios also show that the output holds its value between strobes.

// File: rtl/hclPkg.sv
package hclPkg;

  typedef enum logic [1:0] {
    MODE_CLAMP  = 2'b00,
    MODE_HALF   = 2'b01,
    MODE_WHOLE  = 2'b10,
    MODE_BYPASS = 2'b11
  } hclMode_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;    // load stage 1
    logic advance;    // load stage 2
    logic satMode;    // clamp instead of scale
    logic commonLim;  // use the smaller limit for both halves
    logic bypass;     // pass through untouched
  } hclCtrl_t;

endpackage

// File: rtl/hclControl.sv
module hclControl
  import hclPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] mode,
  output hclCtrl_t   ctrl,
  output logic       outValid
);

  logic     s1Valid;
  hclMode_e modeSel;

  assign modeSel = hclMode_e'(mode);

  always_comb begin
    ctrl.capture   = inValid;
    ctrl.advance   = s1Valid;
    ctrl.satMode   = (modeSel == MODE_CLAMP);
    ctrl.commonLim = (modeSel == MODE_WHOLE);
    ctrl.bypass    = (modeSel == MODE_BYPASS);
  end

  // Valid strobe follows the two data stages
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= inValid;
      outValid <= s1Valid;
    end
  end

endmodule

// File: rtl/hclDatapath.sv
module hclDatapath
  import hclPkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int LIM_W    = 10,
  parameter int LIM_MAX  = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  hclCtrl_t            ctrl,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic [LIM_W-1:0]    posLimit,
  input  logic [LIM_W-1:0]    negLimit,
  output logic [SAMPLE_W-1:0] outSample
);

  localparam int MID     = 1 << (SAMPLE_W - 1);
  localparam int POS_FS  = MID - 1;
  localparam int NEG_FS  = MID;
  localparam int PROD_W  = SAMPLE_W + LIM_W + 1;
  localparam int HALVES  = 2;
  localparam int IDX_POS = 0;
  localparam int IDX_NEG = 1;

  // ---------------- limit conditioning (one per half) ----------------
  logic [LIM_W-1:0] limRaw [HALVES];
  logic [LIM_W-1:0] limEff [HALVES];

  assign limRaw[IDX_POS] = posLimit;
  assign limRaw[IDX_NEG] = negLimit;

  for (genvar h = 0; h < HALVES; h++) begin : g_limClamp
    assign limEff[h] = (limRaw[h] > LIM_W'(LIM_MAX)) ? LIM_W'(LIM_MAX) : limRaw[h];
  end

  // ---------------- stage 1: split sign and magnitude ----------------
  logic                isNeg;
  logic [SAMPLE_W-1:0] magIn;
  logic [LIM_W-1:0]    halfLim;
  logic [LIM_W-1:0]    minLim;
  logic [LIM_W-1:0]    selLim;

  always_comb begin
    isNeg   = (inSample < SAMPLE_W'(MID));
    magIn   = isNeg ? (SAMPLE_W'(MID) - inSample) : (inSample - SAMPLE_W'(MID));
    halfLim = isNeg ? limEff[IDX_NEG] : limEff[IDX_POS];
    minLim  = (limEff[IDX_POS] < limEff[IDX_NEG]) ? limEff[IDX_POS] : limEff[IDX_NEG];
    selLim  = ctrl.commonLim ? minLim : halfLim;
  end

  logic                s1Neg;
  logic [SAMPLE_W-1:0] s1Mag;
  logic [LIM_W-1:0]    s1Lim;
  logic                s1Sat;
  logic                s1Bypass;
  logic [SAMPLE_W-1:0] s1Raw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Neg    <= 1'b0;
      s1Mag    <= '0;
      s1Lim    <= LIM_W'(LIM_MAX);
      s1Sat    <= 1'b0;
      s1Bypass <= 1'b0;
      s1Raw    <= SAMPLE_W'(MID);
    end else if (ctrl.capture) begin
      s1Neg    <= isNeg;
      s1Mag    <= magIn;
      s1Lim    <= selLim;
      s1Sat    <= ctrl.satMode;
      s1Bypass <= ctrl.bypass;
      s1Raw    <= inSample;
    end
  end

  // ---------------- stage 2: scale or clamp, rebuild sample ----------------
  logic [PROD_W-1:0]   fsMag;
  logic [PROD_W-1:0]   scaled;
  logic [PROD_W-1:0]   thresh;
  logic [PROD_W-1:0]   satMag;
  logic [SAMPLE_W-1:0] newMag;
  logic [SAMPLE_W-1:0] rebuilt;

  always_comb begin
    fsMag   = s1Neg ? PROD_W'(NEG_FS) : PROD_W'(POS_FS);
    scaled  = (PROD_W'(s1Mag) * PROD_W'(s1Lim)) / PROD_W'(LIM_MAX);
    thresh  = (fsMag * PROD_W'(s1Lim)) / PROD_W'(LIM_MAX);
    satMag  = (PROD_W'(s1Mag) <= thresh) ? PROD_W'(s1Mag) : thresh;
    newMag  = s1Sat ? SAMPLE_W'(satMag) : SAMPLE_W'(scaled);
    rebuilt = s1Neg ? (SAMPLE_W'(MID) - newMag) : (SAMPLE_W'(MID) + newMag);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSample <= SAMPLE_W'(MID);
    end else if (ctrl.advance) begin
      outSample <= s1Bypass ? s1Raw : rebuilt;
    end
  end

endmodule

// File: rtl/halfCycleLimiter.sv
module halfCycleLimiter
  import hclPkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int LIM_W    = 10,
  parameter int LIM_MAX  = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic [LIM_W-1:0]    posLimit,
  input  logic [LIM_W-1:0]    negLimit,
  input  logic [1:0]          mode,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outSample
);

  hclCtrl_t ctrl;

  hclControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .mode     (mode),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  hclDatapath #(
    .SAMPLE_W (SAMPLE_W),
    .LIM_W    (LIM_W),
    .LIM_MAX  (LIM_MAX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .inSample  (inSample),
    .posLimit  (posLimit),
    .negLimit  (negLimit),
    .outSample (outSample)
  );

endmodule

// File: rtl/hclChecker.sv
module hclChecker #(
  parameter int SAMPLE_W = 8,
  parameter int LIM_W    = 10,
  parameter int LIM_MAX  = 1000
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [SAMPLE_W-1:0] inSample,
  input logic [LIM_W-1:0]    posLimit,
  input logic [LIM_W-1:0]    negLimit,
  input logic [1:0]          mode,
  input logic                outValid,
  input logic [SAMPLE_W-1:0] outSample
);

  localparam int MID = 1 << (SAMPLE_W - 1);

  // Edges since reset release, saturating
  logic [1:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic warm;
  assign warm = (age >= 2'd2);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (outValid == $past(inValid, 2)));

  p_side_r9: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid) |->
      (($past(inSample, 2) >= SAMPLE_W'(MID)) ? (outSample >= SAMPLE_W'(MID))
                                              : (outSample <= SAMPLE_W'(MID))));

  p_no_grow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid) |->
      (($past(inSample, 2) >= SAMPLE_W'(MID)) ? (outSample <= $past(inSample, 2))
                                              : (outSample >= $past(inSample, 2))));

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid && ($past(mode, 2) == 2'b11)) |-> (outSample == $past(inSample, 2)));

  p_unity_pos_r6: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid && ($past(mode, 2) <= 2'b01) && ($past(inSample, 2) >= SAMPLE_W'(MID))
     && ($past(posLimit, 2) >= LIM_W'(LIM_MAX))) |-> (outSample == $past(inSample, 2)));

  p_unity_neg_r6: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid && ($past(mode, 2) <= 2'b01) && ($past(inSample, 2) < SAMPLE_W'(MID))
     && ($past(negLimit, 2) >= LIM_W'(LIM_MAX))) |-> (outSample == $past(inSample, 2)));

endmodule

bind halfCycleLimiter hclChecker #(
  .SAMPLE_W (SAMPLE_W),
  .LIM_W    (LIM_W),
  .LIM_MAX  (LIM_MAX)
) u_chk (.*);

// File: tb/halfCycleLimiter_tb.sv
module halfCycleLimiter_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inSample = 8'd128;
  logic [9:0] posLimit = 10'd1000;
  logic [9:0] negLimit = 10'd1000;
  logic [1:0] mode = 2'b00;
  logic       outValid;
  logic [7:0] outSample;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  halfCycleLimiter u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inSample  (inSample),
    .posLimit  (posLimit),
    .negLimit  (negLimit),
    .mode      (mode),
    .outValid  (outValid),
    .outSample (outSample)
  );

  typedef struct packed {
    logic [7:0] smp;
    logic [9:0] pos;
    logic [9:0] neg;
    logic [1:0] md;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'd255, 10'd500,  10'd1000, 2'b00, 8'd191}, // R3 clamp to 63
    '{8'd150, 10'd500,  10'd1000, 2'b00, 8'd150}, // R3 inside threshold
    '{8'd0,   10'd1000, 10'd250,  2'b00, 8'd96 }, // R3 R2 neg FS 128 -> 32
    '{8'd255, 10'd500,  10'd0,    2'b01, 8'd191}, // R4 R2 63.5 -> 63
    '{8'd0,   10'd0,    10'd333,  2'b01, 8'd86 }, // R4 neg 42
    '{8'd200, 10'd1000, 10'd0,    2'b01, 8'd200}, // R6 R4 unity half
    '{8'd255, 10'd800,  10'd300,  2'b10, 8'd166}, // R5 min = neg limit
    '{8'd64,  10'd800,  10'd300,  2'b10, 8'd109}, // R5 neg half 19
    '{8'd0,   10'd250,  10'd900,  2'b10, 8'd96 }, // R5 min = pos limit
    '{8'd37,  10'd0,    10'd0,    2'b11, 8'd37 }, // R7 bypass
    '{8'd200, 10'd0,    10'd1000, 2'b00, 8'd128}, // R3 zero limit
    '{8'd10,  10'd0,    10'd1023, 2'b01, 8'd10 }, // R8 1023 acts as 1000
    '{8'd128, 10'd100,  10'd100,  2'b10, 8'd128}, // R2 zero stays zero
    '{8'd1,   10'd1000, 10'd999,  2'b01, 8'd2  }, // R2 126.87 -> 126
    '{8'd129, 10'd7,    10'd1000, 2'b00, 8'd128}, // R2 R3 threshold 0
    '{8'd250, 10'd1010, 10'd1010, 2'b10, 8'd250}  // R8 R6 both over range
  };

  function automatic string reqOf(input logic [1:0] md);
    case (md)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset state: R1 valid low, R10 sample at midpoint
    repeat (3) @(negedge clk);
    check("R1 reset outValid", int'(outValid), 0);
    check("R10 reset outSample", int'(outSample), 128);
    rstN = 1'b1;
    @(negedge clk);

    // Streamed vector table, one sample per clock
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        check({reqOf(VECS[i-2].md), " valid"}, int'(outValid), 1);
        check(reqOf(VECS[i-2].md), int'(outSample), int'(VECS[i-2].exp));
      end
      if (i < NV) begin
        inValid  = 1'b1;
        inSample = VECS[i].smp;
        posLimit = VECS[i].pos;
        negLimit = VECS[i].neg;
        mode     = VECS[i].md;
      end else begin
        inValid  = 1'b0;
        inSample = 8'd3;
        mode     = 2'b11;
      end
      @(negedge clk);
    end

    // R10: no strobe, output holds last value (250)
    check("R10 hold valid", int'(outValid), 0);
    check("R10 hold sample", int'(outSample), 250);

    // R1: single strobe emerges exactly two edges later
    inValid = 1'b1; inSample = 8'd240; mode = 2'b01; posLimit = 10'd500; negLimit = 10'd1000;
    @(negedge clk);
    inValid = 1'b0; inSample = 8'd5;
    check("R1 one edge", int'(outValid), 0);
    @(negedge clk);
    check("R1 two edges", int'(outValid), 1);
    check("R4 R1 value", int'(outSample), 184);  // 112*0.5 = 56
    @(negedge clk);
    check("R1 strobe ends", int'(outValid), 0);
    check("R10 held after strobe", int'(outSample), 184);

    // R4: other half's limit has no effect on a negative sample
    inValid = 1'b1; inSample = 8'd28; mode = 2'b01; posLimit = 10'd0; negLimit = 10'd1000;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check("R4 other limit ignored", int'(outSample), 28);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule